// File: doc/BRIEF.md
# Fault Error Record and Interrupt Unit

This block gathers the parity-error flags raised by up to thirteen protected functional units and keeps one error record for software. When detection is switched on and a unit reports a fault, the record latches a fixed description: valid, uncorrected, uncontainable, a syndrome that marks the error as a flop-parity fault, and a five-bit code that names the reporting unit. A fault handling interrupt is raised at the same time. The block does not attempt any recovery or containment.

The record then stays frozen until software clears it. Any further fault that arrives in the meantime only sets an overflow flag. Detection needs two control bits to be set at once: a global enable and an enable for flop-parity reporting.

Software reaches the block through a plain single-cycle register port. A write is taken on the clock edge at which `reg_wr` is high. A read is combinational from `reg_sel`. The port has no back-pressure and every access completes at once. The unit flag inputs are sampled on every edge and are not handshaked either. A flag seen while detection is disabled is simply dropped.

Top module: `fault_err_record`

## Requirements
- R1: After reset both control bits are 0, the status word reads 0 and `fault_irq` is 0.
- R2: A write with `reg_sel`=0 loads the global enable from `reg_wdata[0]` and the parity enable from `reg_wdata[33]`. A read with `reg_sel`=0 returns those two bits in the same positions and 0 in every other bit.
- R3: Unit flags are ignored unless both control bits are 1. With either bit 0, the status word stays 0 and `fault_irq` stays 0.
- R4: A captured record reads, with `reg_sel`=1, as follows: valid in bit 31 is 1, uncorrected in bit 29 is 1, type in bits [25:24] is 2'b00 (uncontainable), syndrome in bits [7:0] is 0x1A, and unit code in bits [20:16] is 4 plus the flag index. Index 0 maps to 0b00100 and index 12 maps to 0b10000.
- R5: When several flags are high in the capture cycle, the lowest index, and so the lowest code, is recorded.
- R6: While valid is 1, new flags do not change the recorded code.
- R7: An enabled flag arriving while valid is 1 sets the overflow bit, bit 30.
- R8: `fault_irq` equals the valid bit. It rises in the cycle after the clock edge that captures an error.
- R9: A status write (`reg_sel`=1) with bit 31 set clears the whole record, so the status reads 0. A status write with only bit 30 set clears overflow alone. A status write with zeros changes nothing.
- R10: If a status write that clears valid meets an enabled flag on the same edge, the new error is captured and overflow reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_err | input | 13 | Per-unit parity error flags; index i maps to code 4+i |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| fault_irq | output | 1 | Fault handling interrupt, high while a record is held |

## Verification
Two events can meet on a single edge: the software clear of the record, and a fresh unit fault. The bench provokes this by issuing a valid-clearing status write in the same cycle that it raises flags. A correct design must then hold the new lowest-index code with overflow at 0, and must keep the interrupt high without a gap. The same collision is also run with an overflow-only clear, where a set of overflow must win over its clear, and with a control write that enables detection while a flag is high, where the old enables must apply. A cycle-level model in the bench decides the expected result in every case, and a long sparse random phase repeats these collisions.

// File: rtl/fer_pkg.sv
package fer_pkg;
  localparam int unsigned REG_W        = 64;
  localparam int unsigned CODE_W       = 5;
  localparam int unsigned SYN_W        = 8;
  localparam int unsigned CODE_BASE    = 4;

  localparam int unsigned CTL_ED_BIT   = 0;
  localparam int unsigned CTL_PAR_BIT  = 33;

  localparam int unsigned ST_VALID_BIT = 31;
  localparam int unsigned ST_OVF_BIT   = 30;
  localparam int unsigned ST_UE_BIT    = 29;
  localparam int unsigned ST_TYPE_LSB  = 24;
  localparam int unsigned ST_CODE_LSB  = 16;
  localparam int unsigned ST_SYN_LSB   = 0;

  localparam logic [SYN_W-1:0] SYN_FLOP_PARITY    = 8'h1A;
  localparam logic [1:0]       TYPE_UNCONTAINABLE = 2'b00;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              valid;
    logic              ovf;
    logic [CODE_W-1:0] code;
  } err_rec_t;
endpackage

// File: rtl/fer_ctrl.sv
module fer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic ed_in,
  input  logic par_in,
  output logic ed_q,
  output logic par_q,
  output logic det_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ed_q  <= 1'b0;
      par_q <= 1'b0;
    end else if (wr_ctrl) begin
      ed_q  <= ed_in;
      par_q <= par_in;
    end
  end

  assign det_en = ed_q & par_q;
endmodule

// File: rtl/fer_prio.sv
module fer_prio #(
  parameter int unsigned NUM_UNITS = 13,
  parameter int unsigned BASE      = 4,
  parameter int unsigned CW        = 5
) (
  input  logic [NUM_UNITS-1:0] flags,
  output logic                 any,
  output logic [CW-1:0]        code
);
  function automatic logic [NUM_UNITS-1:0] bit_mask(input int b);
    logic [NUM_UNITS-1:0] m;
    for (int i = 0; i < NUM_UNITS; i++) begin
      m[i] = (((i + BASE) >> b) % 2) == 1;
    end
    return m;
  endfunction

  logic [NUM_UNITS-1:0] lowest;

  assign any    = |flags;
  assign lowest = flags & (~flags + 1'b1);

  for (genvar b = 0; b < CW; b++) begin : g_code_bit
    localparam logic [NUM_UNITS-1:0] MASK = bit_mask(b);
    assign code[b] = |(lowest & MASK);
  end
endmodule

// File: rtl/fer_record.sv
module fer_record
  import fer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [CODE_W-1:0] hit_code,
  input  logic              clr_all,
  input  logic              clr_ovf,
  output err_rec_t          rec
);
  err_rec_t nxt;
  logic     held;

  always_comb begin
    nxt      = rec;
    held     = rec.valid & ~clr_all;
    nxt.ovf  = rec.ovf & ~clr_ovf & ~clr_all;
    if (clr_all) begin
      nxt.valid = 1'b0;
      nxt.code  = '0;
    end
    if (hit) begin
      if (held) begin
        nxt.ovf = 1'b1;
      end else begin
        nxt.valid = 1'b1;
        nxt.ovf   = 1'b0;
        nxt.code  = hit_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec <= '0;
    else        rec <= nxt;
  end
endmodule

// File: rtl/fault_err_record.sv
module fault_err_record
  import fer_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] unit_err,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 fault_irq
);
  logic              ed_q, par_q, det_en;
  logic              any_flag, hit;
  logic [CODE_W-1:0] prio_code;
  logic              wr_ctrl, wr_stat, clr_all, clr_ovf;
  err_rec_t          rec;
  logic [REG_W-1:0]  ctrl_word, status_word;

  assign wr_ctrl = reg_wr & (reg_sel == SEL_CTRL);
  assign wr_stat = reg_wr & (reg_sel == SEL_STATUS);
  assign clr_all = wr_stat & reg_wdata[ST_VALID_BIT];
  assign clr_ovf = wr_stat & reg_wdata[ST_OVF_BIT];

  fer_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .ed_in  (reg_wdata[CTL_ED_BIT]),
    .par_in (reg_wdata[CTL_PAR_BIT]),
    .ed_q   (ed_q),
    .par_q  (par_q),
    .det_en (det_en)
  );

  fer_prio #(
    .NUM_UNITS(NUM_UNITS),
    .BASE     (CODE_BASE),
    .CW       (CODE_W)
  ) u_prio (
    .flags(unit_err),
    .any  (any_flag),
    .code (prio_code)
  );

  assign hit = det_en & any_flag;

  fer_record u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .hit_code(prio_code),
    .clr_all (clr_all),
    .clr_ovf (clr_ovf),
    .rec     (rec)
  );

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CTL_ED_BIT]  = ed_q;
    ctrl_word[CTL_PAR_BIT] = par_q;

    status_word = '0;
    if (rec.valid) begin
      status_word[ST_VALID_BIT]                   = 1'b1;
      status_word[ST_OVF_BIT]                     = rec.ovf;
      status_word[ST_UE_BIT]                      = 1'b1;
      status_word[ST_TYPE_LSB +: 2]               = TYPE_UNCONTAINABLE;
      status_word[ST_CODE_LSB +: CODE_W]          = rec.code;
      status_word[ST_SYN_LSB +: SYN_W]            = SYN_FLOP_PARITY;
    end
  end

  assign reg_rdata = (reg_sel == SEL_STATUS) ? status_word : ctrl_word;
  assign fault_irq = rec.valid;
endmodule

// File: rtl/fer_chk.sv
module fer_chk
  import fer_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_UNITS-1:0] flags,
  input logic                 reg_wr,
  input logic                 reg_sel,
  input logic [REG_W-1:0]     reg_wdata,
  input logic                 det_en,
  input logic [REG_W-1:0]     status_word,
  input logic                 irq
);
  logic clr_v;
  assign clr_v = reg_wr & reg_sel & reg_wdata[ST_VALID_BIT];

  assert_irq_needs_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(det_en && (|flags)));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !det_en) |=> !irq);

  assert_record_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_v) |=> (irq && $stable(status_word[ST_CODE_LSB +: CODE_W])));

  assert_overflow_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_v && det_en && (|flags)) |=> status_word[ST_OVF_BIT]);

  assert_fixed_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_word[ST_UE_BIT] && status_word[ST_TYPE_LSB +: 2] == TYPE_UNCONTAINABLE
             && status_word[ST_SYN_LSB +: SYN_W] == SYN_FLOP_PARITY));

  assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_word[ST_CODE_LSB +: CODE_W] >= CODE_BASE
             && status_word[ST_CODE_LSB +: CODE_W] < CODE_BASE + NUM_UNITS));
endmodule

bind fault_err_record fer_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flags      (unit_err),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .det_en     (det_en),
  .status_word(status_word),
  .irq        (fault_irq)
);

// File: tb/sim_fault_err_record.sv
`timescale 1ns/1ps
module sim_fault_err_record;
  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] unit_err = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        fault_irq;

  int vectors = 0;
  int errors  = 0;

  bit m_ed, m_par, m_v, m_of;
  int m_code;

  always #5 clk = ~clk;

  fault_err_record #(.NUM_UNITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .unit_err(unit_err), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fault_irq(fault_irq)
  );

  function automatic logic [63:0] exp_word(bit sel);
    logic [63:0] w = '0;
    if (!sel) begin
      w[0]  = m_ed;
      w[33] = m_par;
    end else if (m_v) begin
      w[31] = 1'b1;
      w[30] = m_of;
      w[29] = 1'b1;
      w[20:16] = m_code[4:0];
      w[7:0] = 8'h1A;
    end
    return w;
  endfunction

  task automatic model_edge();
    bit hit, keep, clr_v, clr_o;
    int low;
    low = -1;
    for (int i = N - 1; i >= 0; i--) if (unit_err[i]) low = i;
    hit   = m_ed && m_par && (low >= 0);
    clr_v = reg_wr && reg_sel && reg_wdata[31];
    clr_o = reg_wr && reg_sel && reg_wdata[30];
    keep  = m_v && !clr_v;
    if (clr_v) begin m_v = 0; m_of = 0; end
    if (clr_o) m_of = 0;
    if (hit) begin
      if (keep) m_of = 1;
      else begin m_v = 1; m_of = 0; m_code = low + 4; end
    end
    if (reg_wr && !reg_sel) begin
      m_ed  = reg_wdata[0];
      m_par = reg_wdata[33];
    end
  endtask

  task automatic compare(string tag);
    logic [63:0] e;
    e = exp_word(reg_sel);
    vectors++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s rdata sel=%0b actual=%h expected=%h", tag, reg_sel, reg_rdata, e);
    end
    vectors++;
    if (fault_irq !== m_v) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, fault_irq, m_v);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit wr, bit sel, logic [63:0] wd, logic [N-1:0] fl, string tag);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; unit_err = fl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic peek(bit sel, string tag);
    cyc(1'b0, sel, 64'h0, '0, tag);
  endtask

  localparam logic [63:0] EN_BOTH = (64'h1 << 33) | 64'h1;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_ed = 0; m_par = 0; m_v = 0; m_of = 0; m_code = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    peek(1'b0, "R1"); peek(1'b1, "R1");

    // R2 control readback, only bits 0 and 33 stored
    cyc(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R2");
    peek(1'b0, "R2");
    cyc(1'b1, 1'b0, 64'h0, '0, "R2");

    // R3 each enable alone ignores flags
    cyc(1'b1, 1'b0, 64'h1, '0, "R3");
    cyc(1'b0, 1'b1, 64'h0, 13'h1FFF, "R3");
    peek(1'b1, "R3");
    cyc(1'b1, 1'b0, 64'h1 << 33, '0, "R3");
    cyc(1'b0, 1'b1, 64'h0, 13'h0040, "R3");
    peek(1'b1, "R3");

    // R2/R3 enabling while a flag is high: old enables apply on that edge
    cyc(1'b1, 1'b0, EN_BOTH, 13'h0001, "R3");
    peek(1'b1, "R3");

    // R4/R8 single fault on highest unit: code 0b10000
    cyc(1'b0, 1'b1, 64'h0, 13'h1000, "R8");
    peek(1'b1, "R4");

    // R6/R7 held record, overflow
    cyc(1'b0, 1'b1, 64'h0, 13'h0001, "R6");
    peek(1'b1, "R7");

    // R9 zero write no effect, overflow-only clear, full clear
    cyc(1'b1, 1'b1, 64'h0, '0, "R9");
    cyc(1'b1, 1'b1, 64'h1 << 30, '0, "R9");
    peek(1'b1, "R9");
    cyc(1'b1, 1'b1, 64'h1 << 31, '0, "R9");
    peek(1'b1, "R9");

    // R5 simultaneous flags: index 5 wins over 6 and 11
    cyc(1'b0, 1'b1, 64'h0, 13'h0860, "R5");
    peek(1'b1, "R5");

    // R7 overflow set beats overflow clear on same edge
    cyc(1'b1, 1'b1, 64'h1 << 30, 13'h0002, "R7");
    peek(1'b1, "R7");

    // R10 clear valid and new fault on the same edge
    cyc(1'b1, 1'b1, 64'h1 << 31, 13'h0300, "R10");
    peek(1'b1, "R10");
    cyc(1'b1, 1'b1, (64'h1 << 31) | (64'h1 << 30), 13'h0001, "R10");
    peek(1'b1, "R4");
    cyc(1'b1, 1'b1, 64'h1 << 31, '0, "R9");

    // random collisions
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] fl;
      logic [63:0] wd;
      bit wr, sel;
      fl  = (($urandom % 4) == 0) ? N'($urandom) : '0;
      wr  = (($urandom % 5) == 0);
      sel = (($urandom % 8) != 0);
      wd  = {32'($urandom), 32'($urandom)};
      if (!sel && ($urandom % 3 != 0)) wd = wd | EN_BOTH;
      cyc(wr, sel, wd, fl, "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule